// File: doc/BRIEF.md
# NAND Flash Command and Strobe Front End

This block sits between a host register bus and an 8-bit NAND flash device. The host writes command, address, write-data and read-request registers. Each write lands in a four-entry write buffer. A strobe sequencer drains the buffer one entry at a time. It drives the latch-enable lines, the write-enable and read-enable strobes and the chip enable, and it stretches each strobe's low phase by a programmable delay.

A read is a two-step exchange. The host writes any value to the read-request register. It then polls a sticky read-ready interrupt flag, picks up the byte from the read-data register, and clears the flag by writing 1 to it. The ready/busy pin passes through a synchronizer, and its rising edge raises an interrupt flag.

Two trigger bits start a whole-page transfer of 256 or 512 bytes. A page write pulls its bytes from a streaming input and raises a done flag at the end. A page read pushes each captured byte to a streaming output. A self-clearing reset bit flushes the buffer and aborts a page transfer. The strobe cycle already in flight runs to completion.

The sequencer FSM has four states. SQ_IDLE goes to SQ_SETUP when an entry is issued. SQ_SETUP goes to SQ_LOW after one cycle with the latch lines set up. SQ_LOW goes to SQ_HIGH after delay+1 cycles. SQ_HIGH goes back to SQ_IDLE after two cycles, and it pulses done in its last cycle. The page FSM has three states. PG_IDLE goes to PG_READ or PG_WRITE when a trigger is pending, the buffer is empty and the sequencer is idle. Read wins if both triggers are pending. Either page state returns to PG_IDLE after its last byte, or when an abort is taken.

Top module: `nfc_frontend`

## Requirements
- R1: The status register (offset 1) shows the ready pin after synchronization in bit 0. Bit 1 is buffer full. Bit 2 is page write pending or running. Bit 3 is page read pending or running. Bit 4 is buffer empty. After reset, with the pin high, it reads 0x11.
- R2: A write to offset 3 produces one cycle with CLE high and ALE low. A write to offset 4 produces one with ALE high and CLE low. A write to offset 5 produces one with both low. Each of these cycles drives the low data byte while WE is low.
- R3: The control register is at offset 0. Bit 0 selects the large page and bit 1 is the bus-width bit. Bits 5:2 are the read delay and bits 9:6 are the write delay. Each low phase of RE or WE lasts delay+1 clock cycles. Between two low phases both strobes stay high for at least 2 cycles.
- R4: The buffer holds 4 entries and issues them in write order. A write while it is full is dropped and sets interrupt bit 1.
- R5: Interrupt bit 2 sets when the buffer goes from full to not full.
- R6: A write to offset 6 issues an RE cycle. The byte on the data input in the last low cycle is captured. Then interrupt bit 3 sets, and the byte reads back at offset 7.
- R7: The interrupt register is at offset 2. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: The ready pin passes through two flops. A rising edge sets interrupt bit 0 on the third clock edge after the pin rises.
- R9: Page control is at offset 9. Bit 0 starts a page read and bit 1 starts a page write, over PAGE_SMALL bytes or, when control bit 0 is set, PAGE_LARGE bytes. A page write takes one streamed byte per WE cycle and sets interrupt bit 4 at the end. A page read presents every captured byte on the stream output for one cycle.
- R10: Writing 1 to bit 0 at offset 8 sets a bit that reads back as 1. Once the in-flight cycle ends, the buffer is flushed, any page transfer is dropped, and the bit clears.
- R11: CE is low whenever either strobe is low. With no cycle in progress, CE, WE and RE are high and CLE and ALE are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational on bus_addr) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Data driven toward the flash |
| nand_doe | output | 1 | Output enable for nand_dout |
| nand_din | input | 8 | Data from the flash |
| nand_rb | input | 1 | Ready/busy pin, high when ready |
| pg_wr_data | input | 8 | Page-write stream byte |
| pg_wr_take | output | 1 | Consumes pg_wr_data this cycle |
| pg_rd_data | output | 8 | Page-read stream byte |
| pg_rd_valid | output | 1 | pg_rd_data valid this cycle |

## Verification
The bench sets PAGE_SMALL to 4 and PAGE_LARGE to 8. This makes both page-size selections, the last-byte end of a page and the page-done flag reachable within a few hundred cycles. The write buffer keeps its default depth of 4 and the delay fields stay 4 bits wide. With the longest write delay, back-to-back host writes can fill the buffer, hit the overflow drop and then watch the full-to-not-full edge.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_WR   = 2'd2,
        OP_RD   = 2'd3
    } nfc_op_e;

    typedef struct packed {
        nfc_op_e    op;
        logic [7:0] data;
    } nfc_entry_t;

    localparam logic [3:0] REG_CTRL  = 4'h0;
    localparam logic [3:0] REG_STAT  = 4'h1;
    localparam logic [3:0] REG_IRQ   = 4'h2;
    localparam logic [3:0] REG_CMD   = 4'h3;
    localparam logic [3:0] REG_ADDR  = 4'h4;
    localparam logic [3:0] REG_WDATA = 4'h5;
    localparam logic [3:0] REG_RDREQ = 4'h6;
    localparam logic [3:0] REG_RDATA = 4'h7;
    localparam logic [3:0] REG_RESET = 4'h8;
    localparam logic [3:0] REG_PAGE  = 4'h9;

    localparam int IRQ_NBUSY = 0;
    localparam int IRQ_OVF   = 1;
    localparam int IRQ_EDGE  = 2;
    localparam int IRQ_RDRDY = 3;
    localparam int IRQ_PGWR  = 4;
endpackage

// File: rtl/nfc_wbuf.sv
module nfc_wbuf
    import nfc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       push,
    input  nfc_entry_t push_entry,
    input  logic       pop,
    output nfc_entry_t head,
    output logic       full,
    output logic       empty,
    output logic       drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    nfc_entry_t         mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count;
    logic               do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full); // R4
endmodule

// File: rtl/nfc_strobe_seq.sv
module nfc_strobe_seq
    import nfc_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  nfc_op_e          go_op,
    input  logic [7:0]       go_data,
    input  logic [DLY_W-1:0] rd_dly,
    input  logic [DLY_W-1:0] wr_dly,
    input  logic [7:0]       nand_din,
    output logic             idle,
    output logic             done,
    output nfc_op_e          cur_op,
    output logic [7:0]       rdata,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dout,
    output logic             nand_doe
);
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_LOW   = 2'd2,
        SQ_HIGH  = 2'd3
    } sq_state_e;

    sq_state_e        state, state_nx;
    logic [DLY_W-1:0] cnt;
    logic [7:0]       cur_data;
    logic [DLY_W-1:0] cur_dly;
    logic             low_end, high_end;

    assign cur_dly  = (cur_op == OP_RD) ? rd_dly : wr_dly;
    assign low_end  = (state == SQ_LOW) && (cnt == cur_dly);
    assign high_end = (state == SQ_HIGH) && (cnt == DLY_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:  if (go) state_nx = SQ_SETUP;
            SQ_SETUP: state_nx = SQ_LOW;
            SQ_LOW:   if (low_end) state_nx = SQ_HIGH;
            SQ_HIGH:  if (high_end) state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            cur_op   <= OP_CMD;
            cur_data <= '0;
            rdata    <= '0;
        end else begin
            if (state == SQ_IDLE && go) begin
                cur_op   <= go_op;
                cur_data <= go_data;
            end
            if (state != state_nx) cnt <= '0;
            else if (state == SQ_LOW || state == SQ_HIGH) cnt <= cnt + 1'b1;
            if (low_end && cur_op == OP_RD) rdata <= nand_din;
        end
    end

    always_comb begin
        idle      = (state == SQ_IDLE);
        done      = high_end;
        nand_ce_n = (state == SQ_IDLE);
        nand_cle  = (state != SQ_IDLE) && (cur_op == OP_CMD);
        nand_ale  = (state != SQ_IDLE) && (cur_op == OP_ADDR);
        nand_we_n = !((state == SQ_LOW) && (cur_op != OP_RD));
        nand_re_n = !((state == SQ_LOW) && (cur_op == OP_RD));
        nand_doe  = (state != SQ_IDLE) && (cur_op != OP_RD);
        nand_dout = cur_data;
    end

    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R2
    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n && nand_re_n) |-> $past(nand_we_n && nand_re_n, 2)); // R3
endmodule

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_pin,
    output logic rb_sync,
    output logic rb_rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= rb_pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rb_sync = s2;
    assign rb_rise = s2 && !s3;
endmodule

// File: rtl/nfc_frontend.sv
module nfc_frontend
    import nfc_pkg::*;
#(
    parameter int WBUF_DEPTH = 4,
    parameter int DLY_W      = 4,
    parameter int PAGE_SMALL = 256,
    parameter int PAGE_LARGE = 512,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dout,
    output logic              nand_doe,
    input  logic [7:0]        nand_din,
    input  logic              nand_rb,
    input  logic [7:0]        pg_wr_data,
    output logic              pg_wr_take,
    output logic [7:0]        pg_rd_data,
    output logic              pg_rd_valid
);
    localparam int CTRL_W = 2 + 2 * DLY_W;
    localparam int RD_LSB = 2;
    localparam int WR_LSB = 2 + DLY_W;
    localparam int PCNT_W = $clog2(PAGE_LARGE);
    localparam int IRQ_W  = 5;

    typedef enum logic [1:0] {
        PG_IDLE  = 2'd0,
        PG_READ  = 2'd1,
        PG_WRITE = 2'd2
    } pg_state_e;

    // control fields
    logic             pg_large, bus_wide;
    logic [DLY_W-1:0] rd_dly, wr_dly;

    logic [IRQ_W-1:0] irq_stat, irq_set, irq_clr;
    logic [7:0]       rd_byte;
    logic             rst_req, pend_rd, pend_wr;
    pg_state_e        pg_state, pg_state_nx;
    logic [PCNT_W-1:0] pg_cnt, pg_last;

    // buffer
    logic       buf_push, buf_pop, buf_full, buf_empty, buf_drop, buf_flush;
    logic       buf_full_q;
    nfc_entry_t buf_in, buf_head;

    // sequencer
    logic       seq_go, seq_idle, seq_done;
    nfc_op_e    seq_op, seq_cur_op;
    logic [7:0] seq_data, seq_rdata;

    logic rb_sync, rb_rise;
    logic abort, start_rd, start_wr, pg_active, pg_issue, pg_end;
    logic wr_busy, rd_busy;
    logic wr_ctrl, wr_irq, wr_reset, wr_page;
    logic unused_bits;

    assign unused_bits = ^{bus_wdata[DATA_W-1:CTRL_W]};

    assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
    assign wr_irq   = bus_wr && (bus_addr == REG_IRQ);
    assign wr_reset = bus_wr && (bus_addr == REG_RESET);
    assign wr_page  = bus_wr && (bus_addr == REG_PAGE);

    // entry decode into the buffer
    always_comb begin
        buf_push    = 1'b0;
        buf_in.op   = OP_CMD;
        buf_in.data = bus_wdata[7:0];
        if (bus_wr) begin
            unique case (bus_addr)
                REG_CMD:   begin buf_push = 1'b1; buf_in.op = OP_CMD;  end
                REG_ADDR:  begin buf_push = 1'b1; buf_in.op = OP_ADDR; end
                REG_WDATA: begin buf_push = 1'b1; buf_in.op = OP_WR;   end
                REG_RDREQ: begin buf_push = 1'b1; buf_in.op = OP_RD;   end
                default:   buf_push = 1'b0;
            endcase
        end
    end

    nfc_wbuf #(.DEPTH(WBUF_DEPTH)) i_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (buf_flush),
        .push       (buf_push),
        .push_entry (buf_in),
        .pop        (buf_pop),
        .head       (buf_head),
        .full       (buf_full),
        .empty      (buf_empty),
        .drop       (buf_drop)
    );

    nfc_strobe_seq #(.DLY_W(DLY_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (seq_go),
        .go_op     (seq_op),
        .go_data   (seq_data),
        .rd_dly    (rd_dly),
        .wr_dly    (wr_dly),
        .nand_din  (nand_din),
        .idle      (seq_idle),
        .done      (seq_done),
        .cur_op    (seq_cur_op),
        .rdata     (seq_rdata),
        .nand_ce_n (nand_ce_n),
        .nand_cle  (nand_cle),
        .nand_ale  (nand_ale),
        .nand_we_n (nand_we_n),
        .nand_re_n (nand_re_n),
        .nand_dout (nand_dout),
        .nand_doe  (nand_doe)
    );

    nfc_rb_sync i_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rb_pin  (nand_rb),
        .rb_sync (rb_sync),
        .rb_rise (rb_rise)
    );

    // arbitration between buffer entries and page bytes
    assign abort     = rst_req && seq_idle;
    assign buf_flush = abort;
    assign pg_active = (pg_state != PG_IDLE);
    assign start_rd  = !pg_active && pend_rd && buf_empty && seq_idle && !rst_req;
    assign start_wr  = !pg_active && pend_wr && !pend_rd && buf_empty && seq_idle && !rst_req;
    assign pg_issue  = pg_active && seq_idle && !rst_req;
    assign buf_pop   = !pg_active && seq_idle && !buf_empty && !rst_req;
    assign seq_go    = buf_pop || pg_issue;
    assign pg_last   = pg_large ? PCNT_W'(PAGE_LARGE - 1) : PCNT_W'(PAGE_SMALL - 1);
    assign pg_end    = pg_active && seq_done && (pg_cnt == pg_last);

    always_comb begin
        unique case (pg_state)
            PG_READ:  begin seq_op = OP_RD; seq_data = 8'h00;      end
            PG_WRITE: begin seq_op = OP_WR; seq_data = pg_wr_data; end
            default:  begin seq_op = buf_head.op; seq_data = buf_head.data; end
        endcase
    end

    assign pg_wr_take  = pg_issue && (pg_state == PG_WRITE);
    assign pg_rd_valid = seq_done && (pg_state == PG_READ);
    assign pg_rd_data  = seq_rdata;

    // page FSM
    always_comb begin
        pg_state_nx = pg_state;
        unique case (pg_state)
            PG_IDLE: begin
                if (start_rd)      pg_state_nx = PG_READ;
                else if (start_wr) pg_state_nx = PG_WRITE;
            end
            PG_READ, PG_WRITE: begin
                if (abort || pg_end) pg_state_nx = PG_IDLE;
            end
            default: pg_state_nx = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_state <= PG_IDLE;
        else        pg_state <= pg_state_nx;
    end

    // interrupt sources
    always_comb begin
        irq_set = '0;
        irq_set[IRQ_NBUSY] = rb_rise;
        irq_set[IRQ_OVF]   = buf_drop;
        irq_set[IRQ_EDGE]  = buf_full_q && !buf_full;
        irq_set[IRQ_RDRDY] = seq_done && (seq_cur_op == OP_RD) && !pg_active;
        irq_set[IRQ_PGWR]  = pg_end && (pg_state == PG_WRITE);
        irq_clr = wr_irq ? bus_wdata[IRQ_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_large   <= 1'b0;
            bus_wide   <= 1'b0;
            rd_dly     <= '0;
            wr_dly     <= '0;
            irq_stat   <= '0;
            rd_byte    <= '0;
            rst_req    <= 1'b0;
            pend_rd    <= 1'b0;
            pend_wr    <= 1'b0;
            pg_cnt     <= '0;
            buf_full_q <= 1'b0;
        end else begin
            buf_full_q <= buf_full;
            irq_stat   <= (irq_stat & ~irq_clr) | irq_set;
            if (wr_ctrl) begin
                pg_large <= bus_wdata[0];
                bus_wide <= bus_wdata[1];
                rd_dly   <= bus_wdata[RD_LSB +: DLY_W];
                wr_dly   <= bus_wdata[WR_LSB +: DLY_W];
            end
            if (irq_set[IRQ_RDRDY]) rd_byte <= seq_rdata;
            if (abort) begin
                rst_req <= 1'b0;
                pend_rd <= 1'b0;
                pend_wr <= 1'b0;
                pg_cnt  <= '0;
            end else begin
                if (wr_reset && bus_wdata[0]) rst_req <= 1'b1;
                if (start_rd)                   pend_rd <= 1'b0;
                else if (wr_page && bus_wdata[0]) pend_rd <= 1'b1;
                if (start_wr)                   pend_wr <= 1'b0;
                else if (wr_page && bus_wdata[1]) pend_wr <= 1'b1;
                if (start_rd || start_wr)       pg_cnt <= '0;
                else if (pg_active && seq_done) pg_cnt <= pg_cnt + 1'b1;
            end
        end
    end

    assign wr_busy = pend_wr || (pg_state == PG_WRITE);
    assign rd_busy = pend_rd || (pg_state == PG_READ);

    // register read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL: begin
                bus_rdata[0] = pg_large;
                bus_rdata[1] = bus_wide;
                bus_rdata[RD_LSB +: DLY_W] = rd_dly;
                bus_rdata[WR_LSB +: DLY_W] = wr_dly;
            end
            REG_STAT:  bus_rdata[4:0] = {buf_empty, rd_busy, wr_busy, buf_full, rb_sync};
            REG_IRQ:   bus_rdata[IRQ_W-1:0] = irq_stat;
            REG_RDATA: bus_rdata[7:0] = rd_byte;
            REG_RESET: bus_rdata[0] = rst_req;
            REG_PAGE:  bus_rdata[1:0] = {wr_busy, rd_busy};
            default:   bus_rdata = '0;
        endcase
    end

    AST_CE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R11
    AST_RB_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_sync) |=> irq_stat[IRQ_NBUSY]); // R8
    AST_RST_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && seq_idle) |=> (!rst_req && buf_empty && pg_state == PG_IDLE)); // R10
    AST_RD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && seq_cur_op == OP_RD && !pg_active) |=> irq_stat[IRQ_RDRDY]); // R6
    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_pop && pg_issue)); // R9
endmodule

// File: tb/test_nfc_frontend.sv
module test_nfc_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
    logic [7:0]  nand_dout;
    logic [7:0]  nand_din;
    logic        nand_rb = 1'b1;
    logic [7:0]  pg_wr_data;
    logic        pg_wr_take;
    logic [7:0]  pg_rd_data;
    logic        pg_rd_valid;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk; // 50 MHz

    nfc_frontend #(.PAGE_SMALL(4), .PAGE_LARGE(8)) i_nfc_frontend (
        .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .nand_ce_n, .nand_cle, .nand_ale, .nand_we_n, .nand_re_n,
        .nand_dout, .nand_doe, .nand_din, .nand_rb,
        .pg_wr_data, .pg_wr_take, .pg_rd_data, .pg_rd_valid
    );

    // flash model and strobe monitor
    int         rd_ptr = 0;
    int         wr_idx = 0;
    assign nand_din   = 8'hA0 + rd_ptr[7:0];
    assign pg_wr_data = 8'h30 + wr_idx[7:0];

    always @(posedge clk) begin
        if (!rst_n) wr_idx <= 0;
        else if (pg_wr_take) wr_idx <= wr_idx + 1;
    end

    logic       log_cle [64];
    logic       log_ale [64];
    logic       log_rd  [64];
    logic [7:0] log_dat [64];
    int         log_len [64];
    int         log_n = 0;
    int         low_run = 0, high_run = 100, min_high = 100, ce_err = 0;
    logic       prev_hi = 1'b1;
    logic       c_cle, c_ale, c_rd;
    logic [7:0] c_dat;
    logic [7:0] pr_dat [16];
    int         pr_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic hi;
            hi = nand_we_n && nand_re_n;
            if (!hi && nand_ce_n) ce_err++;
            if (prev_hi && !hi) begin
                if (high_run < min_high) min_high = high_run;
                low_run = 1;
                c_cle = nand_cle; c_ale = nand_ale; c_rd = !nand_re_n; c_dat = nand_dout;
            end else if (!hi) begin
                low_run++;
            end
            if (!prev_hi && hi) begin
                if (log_n < 64) begin
                    log_cle[log_n] = c_cle; log_ale[log_n] = c_ale;
                    log_rd[log_n] = c_rd;   log_dat[log_n] = c_dat;
                    log_len[log_n] = low_run;
                    log_n++;
                end
                if (c_rd) rd_ptr++;
                high_run = 1;
            end else if (hi) begin
                high_run++;
            end
            prev_hi = hi;
            if (pg_rd_valid && pr_n < 16) begin
                pr_dat[pr_n] = pg_rd_data;
                pr_n++;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_quiet();
        logic [15:0] s;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            rd(4'h1, s);
            if (s[4] && !s[2] && !s[3] && nand_ce_n) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_irq(input int bitn);
        logic [15:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(4'h2, s);
            if (s[bitn]) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rd(4'h1, v);
        chk(v == 16'h0011, "R1 status after reset", v, 16'h0011);
        rd(4'h2, v);
        chk(v == 16'h0000, "R1 irq after reset", v, 0);
        chk({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale} == 5'b11100,
            "R11 idle pins", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
    endtask

    task automatic t_cmd_addr();
        int base;
        base = log_n;
        wr(4'h0, 16'h0080);          // wr_dly = 2
        wr(4'h3, 16'h0090);
        wr(4'h4, 16'h0012);
        wr(4'h5, 16'h005A);
        wait_quiet();
        chk(log_n - base == 3, "R2 cycle count", log_n - base, 3);
        chk(log_cle[base] && !log_ale[base] && log_dat[base] == 8'h90, "R2 command cycle",
            {log_cle[base], log_ale[base], log_dat[base]}, {2'b10, 8'h90});
        chk(!log_cle[base+1] && log_ale[base+1] && log_dat[base+1] == 8'h12, "R2 address cycle",
            {log_cle[base+1], log_ale[base+1], log_dat[base+1]}, {2'b01, 8'h12});
        chk(!log_cle[base+2] && !log_ale[base+2] && !log_rd[base+2] && log_dat[base+2] == 8'h5A,
            "R2 data cycle", log_dat[base+2], 8'h5A);
        chk(log_len[base] == 3, "R3 WE low length", log_len[base], 3);
        chk(min_high >= 2, "R3 strobe high gap", min_high, 2);
        chk(ce_err == 0, "R11 CE during strobe", ce_err, 0);
    endtask

    task automatic t_read();
        logic [15:0] v;
        logic [7:0]  exp;
        int base;
        base = log_n;
        exp = 8'hA0 + rd_ptr[7:0];
        wr(4'h0, 16'h000C);          // rd_dly = 3
        wr(4'h6, 16'h1234);
        wait_irq(3);
        rd(4'h2, v);
        chk(v[3], "R6 read ready flag", v, 16'h0008);
        rd(4'h7, v);
        chk(v[7:0] == exp, "R6 read data", v[7:0], exp);
        chk(log_rd[base] && log_len[base] == 4, "R3 RE low length", log_len[base], 4);
        wr(4'h2, 16'h0000);
        rd(4'h2, v);
        chk(v[3], "R7 write 0 keeps flag", v, 16'h0008);
        wr(4'h2, 16'h0008);
        rd(4'h2, v);
        chk(!v[3], "R7 write 1 clears flag", v, 0);
        wait_quiet();
    endtask

    task automatic t_overflow();
        logic [15:0] v;
        int base;
        wr(4'h0, 16'h03C0);          // wr_dly = 15
        wr(4'h2, 16'h001F);
        base = log_n;
        for (int i = 0; i < 6; i++) wr(4'h5, 16'h0010 + 16'(i));
        rd(4'h1, v);
        chk(v[1] && !v[4], "R1 R4 buffer full status", v, 16'h0002);
        rd(4'h2, v);
        chk(v[1], "R4 overflow flag", v, 16'h0002);
        chk(!v[2], "R5 no edge while full", v, 0);
        wait_quiet();
        chk(log_n - base == 5, "R4 dropped entry", log_n - base, 5);
        for (int i = 0; i < 5; i++)
            chk(log_dat[base+i] == 8'h10 + 8'(i), "R4 issue order", log_dat[base+i], 8'h10 + i);
        chk(log_len[base] == 16, "R3 max write delay", log_len[base], 16);
        rd(4'h2, v);
        chk(v[2], "R5 full edge flag", v, 16'h0004);
        wr(4'h2, 16'h001F);
    endtask

    task automatic t_rb();
        logic [15:0] v;
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        rd(4'h1, v);
        chk(!v[0], "R8 busy seen", v, 0);
        nand_rb = 1'b1;
        @(negedge clk);
        rd(4'h2, v);
        chk(!v[0], "R8 sync delay", v, 0);
        repeat (2) @(negedge clk);
        rd(4'h2, v);
        chk(v[0], "R8 not-busy irq", v, 1);
        rd(4'h1, v);
        chk(v[0], "R1 R8 not-busy status", v, 1);
        wr(4'h2, 16'h0001);
    endtask

    task automatic t_page_wr();
        logic [15:0] v;
        int base;
        wr(4'h0, 16'h0040);          // small page, wr_dly = 1
        base = log_n;
        wr(4'h9, 16'h0002);
        rd(4'h1, v);
        chk(v[2], "R1 R9 page write pending", v, 16'h0004);
        wait_irq(4);
        rd(4'h2, v);
        chk(v[4], "R9 page write done", v, 16'h0010);
        wait_quiet();
        chk(log_n - base == 4, "R9 small page length", log_n - base, 4);
        for (int i = 0; i < 4; i++)
            chk(!log_rd[base+i] && !log_cle[base+i] && log_dat[base+i] == 8'h30 + 8'(i),
                "R9 page write byte", log_dat[base+i], 8'h30 + i);
        rd(4'h1, v);
        chk(!v[2], "R9 page write cleared", v, 0);
        wr(4'h2, 16'h001F);
    endtask

    task automatic t_page_rd();
        logic [15:0] v;
        int p0, n0;
        wr(4'h0, 16'h0001);          // large page, rd_dly = 0
        p0 = rd_ptr; n0 = pr_n;
        wr(4'h9, 16'h0001);
        rd(4'h1, v);
        chk(v[3], "R1 R9 page read pending", v, 16'h0008);
        wait_quiet();
        chk(pr_n - n0 == 8, "R9 large page length", pr_n - n0, 8);
        for (int i = 0; i < 8; i++)
            chk(pr_dat[n0+i] == 8'hA0 + 8'(p0 + i), "R9 page read byte", pr_dat[n0+i], 8'hA0 + p0 + i);
        rd(4'h2, v);
        chk(!v[3] && !v[4], "R9 page read leaves single-read flag", v, 0);
    endtask

    task automatic t_reset_reg();
        logic [15:0] v;
        int base;
        wr(4'h0, 16'h03C0);
        base = log_n;
        for (int i = 0; i < 4; i++) wr(4'h3, 16'h0070 + 16'(i));
        wr(4'h8, 16'h0001);
        rd(4'h8, v);
        chk(v[0], "R10 reset bit set", v, 1);
        for (int i = 0; i < 200; i++) begin
            rd(4'h8, v);
            if (!v[0]) break;
            @(negedge clk);
        end
        chk(!v[0], "R10 reset self-clear", v, 0);
        rd(4'h1, v);
        chk(v[4], "R10 buffer flushed", v, 16'h0010);
        wait_quiet();
        chk(log_n - base == 1, "R10 in-flight cycle only", log_n - base, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd_addr();
        t_read();
        t_overflow();
        t_rb();
        t_page_wr();
        t_page_rd();
        t_reset_reg();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule